// File: doc/BRIEF.md
# Segment Presence Map

This block sits in front of a large DRAM-based cache and tells the requester, without touching that cache, whether a given 64-byte line is held there. Memory is divided into aligned 4 KB segments of 64 lines each. The map keeps one entry per tracked segment. An entry is a segment tag plus a 64-bit vector with one bit per line. A lookup that reports absent lets the request go straight to main memory. A lookup that reports present sends the request on to the DRAM cache tag check. The map records only whether a line is present, not where it sits in the cache.

The map is exact. Installing a line into the DRAM cache sets its bit, allocating an entry when the segment is not yet tracked. Evicting a line clears its bit, and an entry whose vector becomes empty is free again. The entries are arranged set-associatively, with least-recently-used choice among the ways of a set.

When a new segment needs a way and its set is full, the least recently used entry is replaced. Its remaining lines must then leave the DRAM cache so that the map stays exact. The block emits one line-address invalidate per remaining line over a valid/ready channel, and it refuses new operations until that walk is finished.

Top module: `smap_top`

## Requirements
- R1: After reset, reqReady is 1, invValid is 0, rspValid is 0, and every lookup reports absent.
- R2: An accepted lookup (reqOp = 0) raises rspValid for exactly the following cycle. In that cycle rspHit is 1 when the line is tracked and 0 when it is not. Install (reqOp = 1) and evict (reqOp = 2) produce no response.
- R3: After an install, a lookup of that line reports present. Other lines of the same segment that were never installed still report absent, so there are no false positives.
- R4: An evict of a tracked line makes its lookup report absent. An evict of a line that is not tracked changes no lookup result.
- R5: An entry whose vector has become empty frees its way. A new segment in that set then takes the way without any invalidate being emitted, and the other entries keep their lines.
- R6: The line index is reqAddr[11:6]. The set index is the SET_W bits starting at bit 12, and the tag is all bits above them. Bits 5:0 have no effect.
- R7: In a full set, an install of an untracked segment replaces the way used least recently. A lookup or install that matches an entry's tag counts as a use; an evict does not.
- R8: On replacement, invAddr presents one line address (segment base + line × 64) for each bit still set in the victim, in ascending line order. The new line is present afterwards and the victim's lines are absent.
- R9: During a walk, invValid stays high and invAddr stays stable until invReady is seen. reqReady is 0 from the cycle after the replacing install until the cycle after the last invalidate handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operation request valid |
| reqReady | output | 1 | Block can accept an operation |
| reqOp | input | 2 | 0 lookup, 1 install, 2 evict, 3 no operation |
| reqAddr | input | ADDR_W | Byte address of the line |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Line is present in the DRAM cache |
| invValid | output | 1 | Invalidate address valid |
| invReady | input | 1 | Invalidate consumer ready |
| invAddr | output | ADDR_W | Line address to invalidate |

## Verification
The bench targets the set-full replacement. A wrong LRU update would evict a recently touched segment and leave its lines reported absent while they are still cached. A walk that skips or reorders bits would emit the wrong invalidate addresses. It also covers a way freed by clearing every bit of its entry; a design that ignored this would trigger a needless replacement and emit invalidates. Random backpressure on the invalidate channel exposes addresses that change while stalled and requests taken mid-walk. Lookups with varied low offset bits and aliased tags in the same set catch a field decode that is off by one bit.

// File: rtl/smap_pkg.sv
package smap_pkg;
  localparam int LINE_OFS_W = 6;
  localparam int SEG_OFS_W  = 12;
  localparam int LINE_IDX_W = SEG_OFS_W - LINE_OFS_W;
  localparam int SEG_LINES  = 1 << LINE_IDX_W;

  typedef enum logic [1:0] {
    OP_LOOKUP  = 2'd0,
    OP_INSTALL = 2'd1,
    OP_EVICT   = 2'd2,
    OP_NOP     = 2'd3
  } mapOp_e;

  typedef struct packed {
    logic lookup;
    logic install;
    logic evict;
    logic walkPop;
  } mapStrobe_t;
endpackage

// File: rtl/smap_datapath.sv
module smap_datapath
  import smap_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              needVictim,
  output logic              walkLast,
  output logic              rspValid,
  output logic              rspHit,
  output logic [ADDR_W-1:0] invAddr
);
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W = ADDR_W - SEG_OFS_W - SET_W;
  localparam int SEGN_W = TAG_W + SET_W;

  logic [SET_W-1:0]      setIdx;
  logic [TAG_W-1:0]      reqTag;
  logic [LINE_IDX_W-1:0] lineIdx;
  logic [SEG_LINES-1:0]  lineBit;

  assign setIdx  = reqAddr[SEG_OFS_W +: SET_W];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign lineIdx = reqAddr[LINE_OFS_W +: LINE_IDX_W];
  assign lineBit = SEG_LINES'(1) << lineIdx;

  logic [TAG_W-1:0]     tagMem [SETS][WAYS];
  logic [SEG_LINES-1:0] vecMem [SETS][WAYS];
  logic [WAY_W-1:0]     ageMem [SETS][WAYS];

  logic [WAYS-1:0] wayHit, wayFree, wayOld;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wayFree[w] = (vecMem[setIdx][w] == '0);
    assign wayHit[w]  = !wayFree[w] && (tagMem[setIdx][w] == reqTag);
    assign wayOld[w]  = (ageMem[setIdx][w] == WAY_W'(WAYS-1));
  end

  logic [WAY_W-1:0] hitIdx, freeIdx, oldIdx, tgtIdx, touchAge;
  logic matchAny, freeAny, touch;

  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    oldIdx  = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (wayHit[w])  hitIdx  = WAY_W'(w);
      if (wayFree[w]) freeIdx = WAY_W'(w);
      if (wayOld[w])  oldIdx  = WAY_W'(w);
    end
  end

  assign matchAny   = |wayHit;
  assign freeAny    = |wayFree;
  assign needVictim = !matchAny && !freeAny;
  assign tgtIdx     = matchAny ? hitIdx : (freeAny ? freeIdx : oldIdx);
  assign touch      = (strb.lookup && matchAny) || strb.install;
  assign touchAge   = ageMem[setIdx][tgtIdx];

  // victim walk state
  logic [SEG_LINES-1:0]  walkVec;
  logic [SEGN_W-1:0]     walkSeg;
  logic [LINE_IDX_W-1:0] walkLow;

  always_comb begin
    walkLow = '0;
    for (int i = SEG_LINES-1; i >= 0; i--) begin
      if (walkVec[i]) walkLow = LINE_IDX_W'(i);
    end
  end

  assign walkLast = ((walkVec & (walkVec - SEG_LINES'(1))) == '0);
  assign invAddr  = {walkSeg, walkLow, {LINE_OFS_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tagMem[s][w] <= '0;
          vecMem[s][w] <= '0;
          ageMem[s][w] <= WAY_W'(w);
        end
      end
      walkVec  <= '0;
      walkSeg  <= '0;
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
    end else begin
      rspValid <= strb.lookup;
      rspHit   <= matchAny && ((vecMem[setIdx][hitIdx] & lineBit) != '0);

      if (touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == tgtIdx)
            ageMem[setIdx][w] <= '0;
          else if (ageMem[setIdx][w] < touchAge)
            ageMem[setIdx][w] <= ageMem[setIdx][w] + WAY_W'(1);
        end
      end

      if (strb.install) begin
        if (matchAny) begin
          vecMem[setIdx][tgtIdx] <= vecMem[setIdx][tgtIdx] | lineBit;
        end else begin
          vecMem[setIdx][tgtIdx] <= lineBit;
          tagMem[setIdx][tgtIdx] <= reqTag;
        end
        if (needVictim) begin
          walkVec <= vecMem[setIdx][oldIdx];
          walkSeg <= {tagMem[setIdx][oldIdx], setIdx};
        end
      end

      if (strb.evict && matchAny)
        vecMem[setIdx][hitIdx] <= vecMem[setIdx][hitIdx] & ~lineBit;

      if (strb.walkPop)
        walkVec <= walkVec & (walkVec - SEG_LINES'(1));
    end
  end

  // R7: recency ranks of the addressed set stay a permutation, one oldest way
  a_r7_single_oldest: assert property (@(posedge clk) disable iff (!rstN)
    $countones(wayOld) == 1);

  // R8: a replacement always starts a walk with at least one line
  a_r8_walk_loaded: assert property (@(posedge clk) disable iff (!rstN)
    (strb.install && needVictim) |=> (walkVec != '0));

  // R8: each pop removes exactly one line from the walk
  a_r8_pop_one: assert property (@(posedge clk) disable iff (!rstN)
    strb.walkPop |=> ($countones(walkVec) == $countones($past(walkVec)) - 1));
endmodule

// File: rtl/smap_control.sv
module smap_control
  import smap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  output logic       reqReady,
  output logic       invValid,
  input  logic       invReady,
  input  logic       needVictim,
  input  logic       walkLast,
  output mapStrobe_t strb
);
  typedef enum logic {ST_IDLE, ST_WALK} ctlState_e;
  ctlState_e state, nextState;

  logic   accept;
  mapOp_e op;

  assign op       = mapOp_e'(reqOp);
  assign reqReady = (state == ST_IDLE);
  assign invValid = (state == ST_WALK);
  assign accept   = reqValid && reqReady;

  always_comb begin
    strb         = '0;
    strb.lookup  = accept && (op == OP_LOOKUP);
    strb.install = accept && (op == OP_INSTALL);
    strb.evict   = accept && (op == OP_EVICT);
    strb.walkPop = invValid && invReady;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: if (strb.install && needVictim) nextState = ST_WALK;
      ST_WALK: if (strb.walkPop && walkLast)   nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R9: at most one action per cycle
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.lookup, strb.install, strb.evict, strb.walkPop}));

  // R9: a stalled invalidate stays offered
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && !invReady) |=> invValid);

  // R9: requests reopen right after the final invalidate
  a_r9_walk_exit: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && invReady && walkLast) |=> reqReady);
endmodule

// File: rtl/smap_top.sv
module smap_top
  import smap_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic              invValid,
  input  logic              invReady,
  output logic [ADDR_W-1:0] invAddr
);
  mapStrobe_t strb;
  logic needVictim, walkLast;

  smap_control u_ctl (
    .clk, .rstN, .reqValid, .reqOp, .reqReady,
    .invValid, .invReady, .needVictim, .walkLast, .strb
  );

  smap_datapath #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_dp (
    .clk, .rstN, .strb, .reqAddr, .needVictim, .walkLast,
    .rspValid, .rspHit, .invAddr
  );

  // R2: a response follows only an accepted lookup
  a_r2_rsp_after_lookup: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady && (reqOp == 2'd0)));

  // R9: a stalled invalidate keeps its address
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && !invReady) |=> $stable(invAddr));

  // R9: no request is taken while invalidates are pending
  a_r9_no_accept_walk: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> !reqReady);
endmodule

// File: tb/tb_smap_top.sv
`timescale 1ns/1ps
module tb_smap_top;
  localparam int AW = 32;
  localparam int NS = 4;
  localparam int NW = 4;

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0;
  logic reqReady;
  logic [1:0] reqOp = 0;
  logic [AW-1:0] reqAddr = '0;
  logic rspValid, rspHit, invValid;
  logic invReady = 0;
  logic [AW-1:0] invAddr;

  always #2.5 clk = ~clk;

  smap_top #(.ADDR_W(AW), .SETS(NS), .WAYS(NW)) dut (
    .clk, .rstN, .reqValid, .reqReady, .reqOp, .reqAddr,
    .rspValid, .rspHit, .invValid, .invReady, .invAddr
  );

  int nChecks = 0;
  int nFail = 0;

  // reference model: per set and way a segment number, a line vector, a use stamp
  int unsigned mSeg [NS][NW];
  logic [63:0] mVec [NS][NW];
  int          mUse [NS][NW];
  int          stamp = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mkAddr(input int unsigned seg, input int line, input int ofs);
    return {seg[19:0], line[5:0], ofs[5:0]};
  endfunction

  function automatic int findWay(input int unsigned seg);
    int s = seg % NS;
    for (int w = 0; w < NW; w++)
      if (mVec[s][w] != 0 && mSeg[s][w] == seg) return w;
    return -1;
  endfunction

  function automatic bit mPresent(input int unsigned seg, input int line);
    int w = findWay(seg);
    return (w >= 0) && mVec[seg % NS][w][line];
  endfunction

  task automatic drain(input int unsigned vSeg, input logic [63:0] vVec);
    for (int i = 0; i < 64; i++) begin
      if (vVec[i]) begin
        bit done = 0;
        while (!done) begin
          chk(invValid == 1, "R9", invValid, 1);
          chk(invAddr == mkAddr(vSeg, i, 0), "R8", invAddr, mkAddr(vSeg, i, 0));
          chk(reqReady == 0, "R9", reqReady, 0);
          invReady = ($urandom % 3) != 0;
          @(negedge clk);
          if (invReady) done = 1;
        end
        invReady = 0;
      end
    end
    chk(invValid == 0, "R9", invValid, 0);
    chk(reqReady == 1, "R9", reqReady, 1);
  endtask

  task automatic doOp(input int op, input int unsigned seg, input int line, input int ofs, input string req);
    int s = seg % NS;
    int w;
    bit expHit;
    bit walk = 0;
    int unsigned vSeg = 0;
    logic [63:0] vVec = 0;
    expHit = mPresent(seg, line);
    w = findWay(seg);
    reqValid = 1;
    reqOp = op[1:0];
    reqAddr = mkAddr(seg, line, ofs);
    chk(reqReady == 1, "R9", reqReady, 1);
    @(negedge clk);
    reqValid = 0;
    reqOp = 2'd3;
    if (op == 0) begin
      chk(rspValid == 1, "R2", rspValid, 1);
      chk(rspHit == expHit, req, rspHit, expHit);
      if (w >= 0) mUse[s][w] = ++stamp;
    end else begin
      chk(rspValid == 0, "R2", rspValid, 0);
      if (op == 1) begin
        if (w >= 0) begin
          mVec[s][w][line] = 1'b1;
          mUse[s][w] = ++stamp;
        end else begin
          int f = -1;
          for (int k = NW-1; k >= 0; k--) if (mVec[s][k] == 0) f = k;
          if (f < 0) begin
            f = 0;
            for (int k = 1; k < NW; k++) if (mUse[s][k] < mUse[s][f]) f = k;
            walk = 1;
            vSeg = mSeg[s][f];
            vVec = mVec[s][f];
          end
          mSeg[s][f] = seg;
          mVec[s][f] = 64'd1 << line;
          mUse[s][f] = ++stamp;
        end
      end else if (op == 2) begin
        if (w >= 0) mVec[s][w][line] = 1'b0;
      end
    end
    if (walk) drain(vSeg, vVec);
    else chk(invValid == 0, req, invValid, 0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        mSeg[s][w] = 0; mVec[s][w] = 0; mUse[s][w] = 0;
      end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: idle state after reset
    chk(reqReady == 1, "R1", reqReady, 1);
    chk(invValid == 0, "R1", invValid, 0);
    chk(rspValid == 0, "R1", rspValid, 0);
    doOp(0, 0, 0, 0, "R1");
    doOp(0, 7, 63, 5, "R1");

    // R3/R6: exact presence and field decode, set 2
    doOp(1, 2, 10, 0, "R3");
    doOp(0, 2, 10, 0, "R3");
    doOp(0, 2, 11, 0, "R3");
    doOp(0, 2, 10, 37, "R6");
    doOp(0, 3, 10, 0, "R6");
    doOp(0, 6, 10, 0, "R6");

    // R4: evict and untracked evict
    doOp(2, 2, 10, 0, "R4");
    doOp(0, 2, 10, 0, "R4");
    doOp(1, 2, 20, 0, "R4");
    doOp(2, 6, 20, 0, "R4");
    doOp(2, 2, 21, 0, "R4");
    doOp(0, 2, 20, 0, "R4");

    // R7/R8: LRU victim and ordered walk, set 0
    doOp(1, 0, 1, 0, "R7");
    doOp(1, 4, 40, 0, "R7");
    doOp(1, 4, 3, 0, "R7");
    doOp(1, 4, 63, 0, "R7");
    doOp(1, 8, 1, 0, "R7");
    doOp(1, 12, 1, 0, "R7");
    doOp(0, 0, 1, 0, "R7");
    doOp(1, 16, 9, 0, "R8");
    doOp(0, 4, 3, 0, "R7");
    doOp(0, 0, 1, 0, "R7");
    doOp(0, 16, 9, 0, "R8");

    // R5: emptied entry frees its way, set 1
    doOp(1, 1, 2, 0, "R5");
    doOp(1, 5, 2, 0, "R5");
    doOp(1, 9, 2, 0, "R5");
    doOp(1, 13, 2, 0, "R5");
    doOp(2, 5, 2, 0, "R5");
    doOp(1, 17, 0, 0, "R5");
    doOp(0, 1, 2, 0, "R5");
    doOp(0, 9, 2, 0, "R5");
    doOp(0, 13, 2, 0, "R5");
    doOp(0, 17, 0, 0, "R5");

    // mixed random traffic
    for (int n = 0; n < 2500; n++) begin
      int unsigned r = $urandom % 10;
      int unsigned seg = $urandom % 24;
      int line = (($urandom % 4) == 0) ? int'($urandom % 64) : int'($urandom % 8);
      int ofs = int'($urandom % 64);
      int op = (r < 4) ? 0 : ((r < 8) ? 1 : 2);
      doOp(op, seg, line, ofs, "R2");
    end
    finishRun();
  end
endmodule